// File: doc/BRIEF.md
# Module Clock Gate Controller

This block switches a bank of module clocks on and off under control of a small memory-mapped register interface. Each control register governs sixteen gates. A write carries a 16-bit field of per-bit update enables in its upper half and the matching on/off values in its lower half. Only the bits whose enable is set change, so software can turn a single clock on or off without first reading the register.

Every gate is a latch-based cell. Its enable can only change while the source clock is low, so switching never produces a shortened pulse. The latched enable is passed through two flops in the source clock's own domain and then two flops in the bus domain. The result is a monitor bit, which software polls after switching to learn that the clock is really running. Monitor register k sits at a fixed distance of 0x180 above control register k. A parameter mask marks gates that have no control bit. These gates run from reset and can never be stopped.

Top module: `mcg_ctrl`

## Requirements
- R1: In a write to a control register, control bit n (n = 0..15) keeps its value when bit n+16 of the write data is 0.
- R2: In a write to a control register, control bit n takes the value of write data bit n when bit n+16 is 1: the value 1 turns the clock on and 0 turns it off.
- R3: A read of a control register returns the stored bits in [15:0] and zeros in [31:16]. The data and rsp_valid appear in the cycle after the request.
- R4: Control register k sits at byte offset CTRL_BASE + 4k and its monitor register sits at CTRL_BASE + 0x180 + 4k. A monitor bit reads 1 only when its gate is running and 0 when it is stopped. Writes to monitor addresses change nothing.
- R5: After a gate is switched on, its monitor bit rises within a bounded time: at most 3 source cycles after the enable is latched, plus two bus cycles. It never rises in the cycle right after the write.
- R6: A gated clock that is on toggles once per source cycle. A gated clock that is off stays low, with no edges.
- R7: A gate marked in FIXED_ON (default: gate 15, bit 15 of control register 0) always runs and its control bit reads 1. A write cannot clear it.
- R8: After reset, every control bit outside FIXED_ON is 0, those gated clocks produce no edges, and their monitor bits read 0.
- R9: A read of an address that is neither a control nor a monitor register returns 0. A write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data: enables in [31:16], values in [15:0] |
| rsp_valid | output | 1 | Read data valid (one cycle after a read request) |
| rsp_rdata | output | 32 | Read data |
| src_clk | input | NUM_REGS*16 | Source clock for each gate |
| gclk | output | NUM_REGS*16 | Gated clock for each gate |

## Verification
The masked-write tests use several write patterns. Some set enables over a sparse set of bits, which checks that only the enabled bits change. Some carry values but no enables, which checks that nothing changes. Some try to clear a fixed-on bit, and some write to a monitor address or an unmapped address, which checks that these writes have no effect. The gate and monitor path is tested three ways. The bench counts edges on gates that are on, off and fixed. It polls a monitor bit right after a switch and then repeatedly, which brackets its latency. It also compares the monitor words with the control words once they have settled, which shows that the monitor is tied to the right gates.

// File: rtl/mcg_pkg.sv
`timescale 1ns/1ps
package mcg_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned HALF_W = WORD_W / 2;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_CTRL = 2'd1,
        ACC_MON  = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/mcg_decode.sv
`timescale 1ns/1ps
module mcg_decode #(
    parameter int unsigned              NUM_REGS  = 2,
    parameter int unsigned              ADDR_W    = 12,
    parameter int unsigned              IDX_W     = 1,
    parameter logic [ADDR_W-1:0]        CTRL_BASE = 12'h040,
    parameter logic [ADDR_W-1:0]        MON_OFS   = 12'h180
) (
    input  logic [ADDR_W-1:0]  addr,
    output mcg_pkg::acc_kind_e kind,
    output logic [IDX_W-1:0]   idx
);
    import mcg_pkg::*;

    always_comb begin
        kind = ACC_NONE;
        idx  = '0;
        for (int i = 0; i < int'(NUM_REGS); i++) begin
            if (addr == CTRL_BASE + ADDR_W'(4 * i)) begin
                kind = ACC_CTRL;
                idx  = IDX_W'(i);
            end
            if (addr == CTRL_BASE + MON_OFS + ADDR_W'(4 * i)) begin
                kind = ACC_MON;
                idx  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/mcg_regfile.sv
`timescale 1ns/1ps
module mcg_regfile #(
    parameter int unsigned NUM_REGS = 2,
    parameter int unsigned IDX_W    = 1,
    parameter logic [NUM_REGS*mcg_pkg::HALF_W-1:0] FIXED_ON = '0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic                               rd_en,
    input  mcg_pkg::acc_kind_e                 kind,
    input  logic [IDX_W-1:0]                   idx,
    input  logic [mcg_pkg::WORD_W-1:0]         wdata,
    input  logic [NUM_REGS*mcg_pkg::HALF_W-1:0] mon_async,
    output logic [NUM_REGS*mcg_pkg::HALF_W-1:0] ctrl_o,
    output logic [mcg_pkg::WORD_W-1:0]         rdata_o,
    output logic                               rvalid_o
);
    import mcg_pkg::*;

    localparam int unsigned NG = NUM_REGS * HALF_W;

    typedef struct packed {
        logic [NG-1:0]     ctrl;
        logic [NG-1:0]     mon_s1;
        logic [NG-1:0]     mon_s2;
        logic [WORD_W-1:0] rdata;
        logic              rvalid;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.mon_s1 = mon_async;
        st_d.mon_s2 = st_q.mon_s1;
        st_d.rvalid = rd_en;
        st_d.rdata  = '0;
        if (wr_en && kind == ACC_CTRL) begin
            for (int b = 0; b < int'(HALF_W); b++) begin
                if (wdata[int'(HALF_W) + b]) begin
                    st_d.ctrl[int'(idx) * int'(HALF_W) + b] = wdata[b];
                end
            end
        end
        st_d.ctrl = st_d.ctrl | FIXED_ON;
        if (rd_en) begin
            case (kind)
                ACC_CTRL: st_d.rdata = {{HALF_W{1'b0}}, st_q.ctrl[int'(idx) * int'(HALF_W) +: HALF_W]};
                ACC_MON:  st_d.rdata = {{HALF_W{1'b0}}, st_q.mon_s2[int'(idx) * int'(HALF_W) +: HALF_W]};
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.ctrl   <= FIXED_ON;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o   = st_q.ctrl;
    assign rdata_o  = st_q.rdata;
    assign rvalid_o = st_q.rvalid;

    for (genvar g = 0; g < int'(NG); g++) begin : g_bit_chk
        localparam int unsigned REG_I = g / HALF_W;
        localparam int unsigned BIT_I = g % HALF_W;

        AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && kind == ACC_CTRL && idx == IDX_W'(REG_I) && !wdata[HALF_W + BIT_I])
            |=> $stable(ctrl_o[g])) else $error("masked bit changed"); // R1

        if (!FIXED_ON[g]) begin : g_upd
            AST_MASK_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && kind == ACC_CTRL && idx == IDX_W'(REG_I) && wdata[HALF_W + BIT_I])
                |=> (ctrl_o[g] == $past(wdata[BIT_I]))) else $error("enabled bit not written"); // R2
        end
    end

    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind == ACC_CTRL) |=> (rvalid_o && rdata_o[WORD_W-1:HALF_W] == '0))
        else $error("control read upper half not zero"); // R3
endmodule

// File: rtl/mcg_gate_cell.sv
`timescale 1ns/1ps
module mcg_gate_cell #(
    parameter int unsigned MAX_LAT = 3
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic en,
    output logic gclk,
    output logic mon
);
    localparam int unsigned CNT_W = $clog2(MAX_LAT + 2);

    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    logic  en_lat;
    sync_t sy_d, sy_q;

    always_latch begin
        if (!rst_n) begin
            en_lat <= 1'b0;
        end else if (!src_clk) begin
            en_lat <= en;
        end
    end

    assign gclk = src_clk & en_lat;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = en_lat;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '0;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign mon = sy_q.s2;

    logic [CNT_W-1:0] lat_cnt_q;

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_cnt_q <= '0;
        end else if (en_lat && !mon) begin
            if (lat_cnt_q != {CNT_W{1'b1}}) begin
                lat_cnt_q <= lat_cnt_q + 1'b1;
            end
        end else begin
            lat_cnt_q <= '0;
        end
    end

    AST_MON_BOUND: assert property (@(posedge src_clk) disable iff (!rst_n)
        lat_cnt_q <= CNT_W'(MAX_LAT)) else $error("monitor latency exceeded"); // R5
endmodule

// File: rtl/mcg_ctrl.sv
`timescale 1ns/1ps
module mcg_ctrl #(
    parameter int unsigned       NUM_REGS  = 2,
    parameter int unsigned       ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 12'h040,
    parameter logic [ADDR_W-1:0] MON_OFS   = 12'h180,
    parameter logic [NUM_REGS*mcg_pkg::HALF_W-1:0] FIXED_ON = 'h8000,
    parameter int unsigned       MAX_LAT   = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    input  logic                                req_write,
    input  logic [ADDR_W-1:0]                   req_addr,
    input  logic [mcg_pkg::WORD_W-1:0]          req_wdata,
    output logic                                rsp_valid,
    output logic [mcg_pkg::WORD_W-1:0]          rsp_rdata,
    input  logic [NUM_REGS*mcg_pkg::HALF_W-1:0] src_clk,
    output logic [NUM_REGS*mcg_pkg::HALF_W-1:0] gclk
);
    import mcg_pkg::*;

    localparam int unsigned NG    = NUM_REGS * HALF_W;
    localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    acc_kind_e        kind;
    logic [IDX_W-1:0] idx;
    logic             wr_en, rd_en;
    logic [NG-1:0]    ctrl, mon_raw;

    assign wr_en = req_valid &  req_write;
    assign rd_en = req_valid & ~req_write;

    mcg_decode #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .CTRL_BASE(CTRL_BASE),
        .MON_OFS  (MON_OFS)
    ) u_dec (
        .addr(req_addr),
        .kind(kind),
        .idx (idx)
    );

    mcg_regfile #(
        .NUM_REGS(NUM_REGS),
        .IDX_W   (IDX_W),
        .FIXED_ON(FIXED_ON)
    ) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .kind     (kind),
        .idx      (idx),
        .wdata    (req_wdata),
        .mon_async(mon_raw),
        .ctrl_o   (ctrl),
        .rdata_o  (rsp_rdata),
        .rvalid_o (rsp_valid)
    );

    for (genvar g = 0; g < int'(NG); g++) begin : g_gate
        mcg_gate_cell #(
            .MAX_LAT(MAX_LAT)
        ) u_cell (
            .src_clk(src_clk[g]),
            .rst_n  (rst_n),
            .en     (ctrl[g]),
            .gclk   (gclk[g]),
            .mon    (mon_raw[g])
        );
    end
endmodule

// File: tb/tb_mcg_ctrl.sv
`timescale 1ns/1ps
module tb_mcg_ctrl;
    localparam int NREG = 2;
    localparam int NG   = NREG * 16;

    logic        clk = 1'b0;
    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [NG-1:0] gclk;

    int n_chk  = 0;
    int n_fail = 0;
    int c15 = 0, c19 = 0, c31 = 0;

    always #2 clk  = ~clk;
    always #4 sclk = ~sclk;

    mcg_ctrl dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .src_clk  ({NG{sclk}}),
        .gclk     (gclk)
    );

    always @(posedge gclk[15]) c15++;
    always @(posedge gclk[19]) c19++;
    always @(posedge gclk[31]) c31++;

    typedef struct packed {
        logic [11:0] waddr;
        logic [31:0] wdata;
        logic [11:0] raddr;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{12'h040, 32'hFFFF_00FF, 12'h040, 32'h0000_80FF},
        '{12'h040, 32'h0000_FFFF, 12'h040, 32'h0000_80FF},
        '{12'h040, 32'h00F0_0000, 12'h040, 32'h0000_800F},
        '{12'h040, 32'h8000_0000, 12'h040, 32'h0000_800F},
        '{12'h044, 32'h0F0F_0505, 12'h044, 32'h0000_0505},
        '{12'h044, 32'h0003_FFFF, 12'h044, 32'h0000_0507},
        '{12'h1C4, 32'hFFFF_FFFF, 12'h044, 32'h0000_0507},
        '{12'h048, 32'hFFFF_FFFF, 12'h040, 32'h0000_800F}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
    endtask

    task automatic count_window(input int n, output int a15, output int a19, output int a31);
        @(negedge sclk);
        c15 = 0; c19 = 0; c31 = 0;
        repeat (n) @(posedge sclk);
        #1;
        a15 = c15; a19 = c19; a31 = c31;
    endtask

    initial begin
        logic [31:0] rd;
        int k15, k19, k31;
        int seen;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // Reset state: R8 (fixed gate 15 reads 1, everything else 0)
        bus_read(12'h040, rd); chk("R8 ctrl0 after reset", rd, 32'h0000_8000);
        bus_read(12'h044, rd); chk("R8 ctrl1 after reset", rd, 32'h0000_0000);
        count_window(10, k15, k19, k31);
        chk("R8 gate31 stopped after reset", 32'(k31), 32'd0);
        bus_read(12'h1C4, rd); chk("R8 mon1 after reset", rd, 32'h0000_0000);

        // Masked write vectors: R1 R2 R3 R4 R9
        for (int i = 0; i < 8; i++) begin
            bus_write(VECS[i].waddr, VECS[i].wdata);
            bus_read(VECS[i].raddr, rd);
            chk($sformatf("R1/R2 vector %0d", i), rd, VECS[i].exp);
        end

        // R4: monitor words follow control words once settled
        repeat (10) @(posedge sclk);
        bus_read(12'h1C0, rd); chk("R4 mon0 settled", rd, 32'h0000_800F);
        bus_read(12'h1C4, rd); chk("R4 mon1 settled", rd, 32'h0000_0507);

        // R5: latency of monitor after switching gate 31 on
        bus_write(12'h044, 32'h8000_8000);
        bus_read(12'h1C4, rd); chk("R5 mon31 not immediate", 32'(rd[15]), 32'd0);
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            if (seen == 0) begin
                bus_read(12'h1C4, rd);
                if (rd[15]) seen = 1;
            end
        end
        chk("R5 mon31 rises within bound", 32'(seen), 32'd1);

        // R6: edge counts on on / off / fixed gates
        count_window(20, k15, k19, k31);
        chk("R6 gate31 on toggles", 32'(k31), 32'd20);
        chk("R6 gate19 off silent", 32'(k19), 32'd0);
        chk("R7 fixed gate15 runs", 32'(k15), 32'd20);

        // R6/R4: switch gate 31 off
        bus_write(12'h044, 32'h8000_0000);
        repeat (6) @(posedge sclk);
        count_window(10, k15, k19, k31);
        chk("R6 gate31 off silent", 32'(k31), 32'd0);
        chk("R6 gate31 held low", 32'(gclk[31]), 32'd0);
        bus_read(12'h1C4, rd); chk("R4 mon31 cleared", rd, 32'h0000_0507);

        // R7: fixed gate cannot be cleared
        bus_write(12'h040, 32'hFFFF_0000);
        bus_read(12'h040, rd); chk("R7 fixed bit stays", rd, 32'h0000_8000);
        repeat (6) @(posedge sclk);
        count_window(10, k15, k19, k31);
        chk("R7 fixed gate still runs", 32'(k15), 32'd10);
        bus_read(12'h1C0, rd); chk("R7 fixed monitor high", rd, 32'h0000_8000);

        // R9: unmapped reads; R3 response timing
        bus_read(12'h048, rd); chk("R9 unmapped 0x048", rd, 32'h0);
        bus_read(12'h000, rd); chk("R9 unmapped 0x000", rd, 32'h0);
        @(negedge clk);
        chk("R3 no rsp_valid when idle", 32'(rsp_valid), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule